// File: doc/BRIEF.md
# Flash Write-Status Poll Path

This block models the read path of a parallel NOR flash while an internal program or erase algorithm is running. A one-cycle start pulse launches either a program of one datum at one address, or an erase of every sector whose bit is set in a sector mask. Per-sector protect flags are sampled at the start. While the block is busy, a read at a valid status address returns a poll word. Bit 7 of that word carries the status and the lower bits read as ones. Once the block is idle again, reads return the stored array contents.

A program runs for a parameterised number of cycles. Its status bit is the inverse of the bit 7 it is writing, and the datum is committed in the last cycle. An erase sweeps the whole array, one word per cycle, and sets every word of each selected, unprotected sector to all-ones. For an erase the status bit reads 0 until the sweep is done. If a program targets a protected sector, or every selected erase sector is protected, the block shows status for a short parameterised timeout. It then returns to array reads with nothing changed. Read data is registered, so an address presented before an edge is answered after it. The array is written in a form that maps onto block RAM.

Top module: `nsp_top`

## Requirements
- R1: A start pulse (start_prog or start_erase) seen while idle sets busy from the next cycle onward. With no start, an idle block stays idle.
- R2: While idle, rd_data after a clock edge equals the array word at the rd_addr presented before that edge.
- R3: A program to an unprotected sector keeps busy for PROG_CYCLES cycles. Reading op_addr meanwhile gives bit 7 equal to the inverse of the datum's bit 7 and all other bits 1. After completion the address reads the programmed datum.
- R4: An erase with at least one selected unprotected sector keeps busy for 2^ADDR_W cycles. Any address in a selected sector reads 0x7F meanwhile (bit 7 = 0). Afterwards the erased words read 0xFF.
- R5: A program whose sector (the top SECT_W address bits) is protected keeps busy for PROG_PROT_CYCLES cycles and shows the inverted-bit-7 status. It then leaves the array unchanged.
- R6: An erase whose selected sectors are all protected keeps busy for ERASE_PROT_CYCLES cycles and reads 0x7F in the selected sectors. It then leaves the array unchanged.
- R7: In an erase with mixed protection, only selected unprotected sectors become 0xFF. Protected and unselected sectors keep their data.
- R8: While busy, a read at an address that is not a valid status address returns all-ones. For a program the only valid address is the program address. For an erase, valid addresses are those inside a selected sector.
- R9: Starts arriving while busy are ignored. The running operation keeps its length and its target, and the ignored start leaves no trace in the array.
- R10: When start_prog and start_erase arrive together while idle, only the program runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Program start pulse |
| start_erase | input | 1 | Erase start pulse |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | DATA_W | Program datum |
| erase_sel | input | 2^SECT_W | Sectors selected for erase |
| sect_prot | input | 2^SECT_W | Per-sector protect flags |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data or status word |
| busy | output | 1 | An operation or protect timeout is running |

## Verification
On every cycle, the assertions check four things: the idle-to-busy transition, the inverted status bit on the program address, the 0x7F word in selected erase sectors, and the all-ones placeholder at invalid program-time addresses. They also check that the captured target cannot change while busy. Only the directed scenarios can show the rest. That covers the operation lengths, what the array holds afterwards under full, partial and no protection, and that an ignored start or a losing erase start leaves the array untouched.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_PPROT,
    ST_ERASE,
    ST_EPROT
  } nsp_state_e;
endpackage

// File: rtl/nsp_array.sv
module nsp_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/nsp_sequencer.sv
module nsp_sequencer
  import nsp_pkg::*;
#(
  parameter int ADDR_W            = 8,
  parameter int DATA_W            = 8,
  parameter int SECT_W            = 2,
  parameter int PROG_CYCLES       = 20,
  parameter int PROG_PROT_CYCLES  = 8,
  parameter int ERASE_PROT_CYCLES = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_prog,
  input  logic                   start_erase,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic [DATA_W-1:0]      op_data,
  input  logic [(1<<SECT_W)-1:0] erase_sel,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  output nsp_state_e             state,
  output logic [ADDR_W-1:0]      op_addr_q,
  output logic [DATA_W-1:0]      op_data_q,
  output logic [(1<<SECT_W)-1:0] sel_q,
  output logic                   wr_en,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data
);
  localparam int NSECT   = 1 << SECT_W;
  localparam int MAX_A   = (PROG_CYCLES > PROG_PROT_CYCLES) ? PROG_CYCLES : PROG_PROT_CYCLES;
  localparam int MAX_CNT = (MAX_A > ERASE_PROT_CYCLES) ? MAX_A : ERASE_PROT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] walk;
  logic [NSECT-1:0]  ers_q;
  logic [NSECT-1:0]  ers_now;
  logic [SECT_W-1:0] prog_sect;
  logic [SECT_W-1:0] walk_sect;

  assign ers_now   = erase_sel & ~sect_prot;
  assign prog_sect = op_addr[ADDR_W-1 -: SECT_W];
  assign walk_sect = walk[ADDR_W-1 -: SECT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      walk      <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      sel_q     <= '0;
      ers_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_prog) begin
            op_addr_q <= op_addr;
            op_data_q <= op_data;
            sel_q     <= '0;
            ers_q     <= '0;
            if (sect_prot[prog_sect]) begin
              state <= ST_PPROT;
              cnt   <= CNT_W'(PROG_PROT_CYCLES - 1);
            end else begin
              state <= ST_PROG;
              cnt   <= CNT_W'(PROG_CYCLES - 1);
            end
          end else if (start_erase) begin
            sel_q <= erase_sel;
            ers_q <= ers_now;
            walk  <= '0;
            if (ers_now == '0) begin
              state <= ST_EPROT;
              cnt   <= CNT_W'(ERASE_PROT_CYCLES - 1);
            end else begin
              state <= ST_ERASE;
            end
          end
        end
        ST_PROG, ST_PPROT, ST_EPROT: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ERASE: begin
          walk <= walk + 1'b1;
          if (walk == {ADDR_W{1'b1}}) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = op_addr_q;
    wr_data = op_data_q;
    if (state == ST_PROG && cnt == '0) begin
      wr_en = 1'b1;
    end else if (state == ST_ERASE) begin
      wr_en   = ers_q[walk_sect];
      wr_addr = walk;
      wr_data = '1;
    end
  end
endmodule

// File: rtl/nsp_status_mux.sv
module nsp_status_mux
  import nsp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  nsp_state_e             state,
  input  logic [ADDR_W-1:0]      op_addr_q,
  input  logic [DATA_W-1:0]      op_data_q,
  input  logic [(1<<SECT_W)-1:0] sel_q,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [DATA_W-1:0]      mem_q,
  output logic [DATA_W-1:0]      rd_data
);
  logic              prog_like;
  logic              erase_like;
  logic              valid;
  logic              flag;
  logic              use_stat_q;
  logic [DATA_W-1:0] stat_q;

  assign prog_like  = (state == ST_PROG)  || (state == ST_PPROT);
  assign erase_like = (state == ST_ERASE) || (state == ST_EPROT);

  always_comb begin
    valid = 1'b0;
    flag  = 1'b0;
    if (prog_like) begin
      valid = (rd_addr == op_addr_q);
      flag  = ~op_data_q[DATA_W-1];
    end else if (erase_like) begin
      valid = sel_q[rd_addr[ADDR_W-1 -: SECT_W]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_stat_q <= 1'b0;
      stat_q     <= '1;
    end else begin
      use_stat_q <= prog_like || erase_like;
      stat_q     <= valid ? {flag, {(DATA_W-1){1'b1}}} : '1;
    end
  end

  assign rd_data = use_stat_q ? stat_q : mem_q;
endmodule

// File: rtl/nsp_top.sv
module nsp_top
  import nsp_pkg::*;
#(
  parameter int ADDR_W            = 8,
  parameter int DATA_W            = 8,
  parameter int SECT_W            = 2,
  parameter int PROG_CYCLES       = 20,
  parameter int PROG_PROT_CYCLES  = 8,
  parameter int ERASE_PROT_CYCLES = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_prog,
  input  logic                   start_erase,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic [DATA_W-1:0]      op_data,
  input  logic [(1<<SECT_W)-1:0] erase_sel,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   busy
);
  nsp_state_e              state;
  logic [ADDR_W-1:0]       op_addr_q;
  logic [DATA_W-1:0]       op_data_q;
  logic [(1<<SECT_W)-1:0]  sel_q;
  logic                    wr_en;
  logic [ADDR_W-1:0]       wr_addr;
  logic [DATA_W-1:0]       wr_data;
  logic [DATA_W-1:0]       mem_q;

  nsp_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYCLES(PROG_CYCLES), .PROG_PROT_CYCLES(PROG_PROT_CYCLES),
    .ERASE_PROT_CYCLES(ERASE_PROT_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(op_addr), .op_data(op_data),
    .erase_sel(erase_sel), .sect_prot(sect_prot),
    .state(state), .op_addr_q(op_addr_q), .op_data_q(op_data_q), .sel_q(sel_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  nsp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .q(mem_q)
  );

  nsp_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_mux (
    .clk(clk), .rst(rst), .state(state),
    .op_addr_q(op_addr_q), .op_data_q(op_data_q), .sel_q(sel_q),
    .rd_addr(rd_addr), .mem_q(mem_q), .rd_data(rd_data)
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker
  import nsp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start_prog,
  input logic                   start_erase,
  input logic                   busy,
  input nsp_state_e             state,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [DATA_W-1:0]      rd_data,
  input logic [ADDR_W-1:0]      op_addr_q,
  input logic [DATA_W-1:0]      op_data_q,
  input logic [(1<<SECT_W)-1:0] sel_q
);
  logic prog_st;
  logic erase_st;
  assign prog_st  = (state == ST_PROG)  || (state == ST_PPROT);
  assign erase_st = (state == ST_ERASE) || (state == ST_EPROT);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && (start_prog || start_erase)) |=> busy); // R1
  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_prog && !start_erase) |=> !busy); // R1
  AST_PROG_FLAG: assert property (@(posedge clk) disable iff (rst)
    (prog_st && rd_addr == op_addr_q) |=>
      (rd_data == {~$past(op_data_q[DATA_W-1]), {(DATA_W-1){1'b1}}})); // R3
  AST_ERASE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (erase_st && sel_q[rd_addr[ADDR_W-1 -: SECT_W]]) |=>
      (rd_data == {1'b0, {(DATA_W-1){1'b1}}})); // R4
  AST_BUSY_PLACEHOLDER: assert property (@(posedge clk) disable iff (rst)
    (prog_st && rd_addr != op_addr_q) |=> (rd_data == {DATA_W{1'b1}})); // R8
  AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      ($stable(op_addr_q) && $stable(op_data_q) && $stable(sel_q))); // R9
endmodule

bind nsp_top nsp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
  .busy(busy), .state(state), .rd_addr(rd_addr), .rd_data(rd_data),
  .op_addr_q(op_addr_q), .op_data_q(op_data_q), .sel_q(sel_q)
);

// File: tb/test_nsp_top.sv
module test_nsp_top;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int SW    = 2;
  localparam int NS    = 1 << SW;
  localparam int PC    = 20;
  localparam int PPC   = 8;
  localparam int EPC   = 40;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_prog = 1'b0;
  logic          start_erase = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic [NS-1:0] erase_sel = '0;
  logic [NS-1:0] sect_prot = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;

  nsp_top #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .PROG_CYCLES(PC),
            .PROG_PROT_CYCLES(PPC), .ERASE_PROT_CYCLES(EPC)) i_nsp_top (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(op_addr), .op_data(op_data), .erase_sel(erase_sel),
    .sect_prot(sect_prot), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic start_op(input logic p, input logic e, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [NS-1:0] sel);
    start_prog = p; start_erase = e; op_addr = a; op_data = d; erase_sel = sel;
    t0 = cyc;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
  endtask

  task automatic wait_done(output int dur);
    while (busy) @(negedge clk);
    dur = cyc - t0 - 1;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);
    rd(8'h00, d);
    chk("R1 idle without start", busy, 0);
  endtask

  task automatic t_chip_erase;
    logic [DW-1:0] d; int dur;
    sect_prot = '0;
    start_op(1'b0, 1'b1, 8'h00, 8'h00, 4'b1111);
    chk("R1 busy after erase start", busy, 1);
    rd(8'hC3, d);
    chk("R4 erase status", d, 8'h7F);
    wait_done(dur);
    chk("R4 erase length", dur, DEPTH);
    rd(8'h00, d);
    chk("R2 erased word", d, 8'hFF);
  endtask

  task automatic t_program;
    logic [DW-1:0] d; int dur;
    start_op(1'b1, 1'b0, 8'h12, 8'hA5, '0);
    rd(8'h12, d);
    chk("R3 program status", d, 8'h7F);
    rd(8'h13, d);
    chk("R8 placeholder", d, 8'hFF);
    wait_done(dur);
    chk("R3 program length", dur, PC);
    rd(8'h12, d);
    chk("R3 programmed datum", d, 8'hA5);
    start_op(1'b1, 1'b0, 8'h50, 8'h3C, '0);
    rd(8'h50, d);
    chk("R3 status with bit7 clear", d, 8'hFF);
    wait_done(dur);
    start_op(1'b1, 1'b0, 8'h90, 8'h11, '0); wait_done(dur);
    start_op(1'b1, 1'b0, 8'hC7, 8'h22, '0); wait_done(dur);
    rd(8'h50, d);
    chk("R2 read 0x50", d, 8'h3C);
    rd(8'hC7, d);
    chk("R2 read 0xC7", d, 8'h22);
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] d; int dur;
    start_op(1'b1, 1'b0, 8'h20, 8'h00, '0);
    rd(8'h20, d);
    start_prog = 1'b1; start_erase = 1'b1;
    op_addr = 8'h21; op_data = 8'h66; erase_sel = 4'b1111;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
    rd(8'h20, d);
    chk("R9 status keeps first target", d, 8'hFF);
    wait_done(dur);
    chk("R9 length unchanged", dur, PC);
    rd(8'h20, d);
    chk("R9 first datum", d, 8'h00);
    rd(8'h21, d);
    chk("R9 ignored program", d, 8'hFF);
    rd(8'h12, d);
    chk("R9 no erase ran", d, 8'hA5);
  endtask

  task automatic t_prot_prog;
    logic [DW-1:0] d; int dur;
    sect_prot = 4'b0001;
    start_op(1'b1, 1'b0, 8'h12, 8'h80, '0);
    rd(8'h12, d);
    chk("R5 protected status", d, 8'h7F);
    wait_done(dur);
    chk("R5 timeout length", dur, PPC);
    rd(8'h12, d);
    chk("R5 array unchanged", d, 8'hA5);
    sect_prot = '0;
  endtask

  task automatic t_prot_erase;
    logic [DW-1:0] d; int dur;
    sect_prot = 4'b0100;
    start_op(1'b0, 1'b1, 8'h00, 8'h00, 4'b0100);
    rd(8'h95, d);
    chk("R6 status in protected sector", d, 8'h7F);
    rd(8'h12, d);
    chk("R8 unselected sector", d, 8'hFF);
    wait_done(dur);
    chk("R6 timeout length", dur, EPC);
    rd(8'h90, d);
    chk("R6 array unchanged", d, 8'h11);
    sect_prot = '0;
  endtask

  task automatic t_partial_erase;
    logic [DW-1:0] d; int dur;
    sect_prot = 4'b0010;
    start_op(1'b0, 1'b1, 8'h00, 8'h00, 4'b0110);
    rd(8'h50, d);
    chk("R4 selected protected sector status", d, 8'h7F);
    wait_done(dur);
    chk("R7 sweep length", dur, DEPTH);
    rd(8'h50, d);
    chk("R7 protected kept", d, 8'h3C);
    rd(8'h90, d);
    chk("R7 unprotected erased", d, 8'hFF);
    rd(8'hC7, d);
    chk("R7 unselected kept", d, 8'h22);
    rd(8'h12, d);
    chk("R7 sector0 kept", d, 8'hA5);
    sect_prot = '0;
  endtask

  task automatic t_both_start;
    logic [DW-1:0] d; int dur;
    start_op(1'b1, 1'b1, 8'h30, 8'h44, 4'b1111);
    wait_done(dur);
    chk("R10 program length", dur, PC);
    rd(8'h30, d);
    chk("R10 programmed", d, 8'h44);
    rd(8'h12, d);
    chk("R10 no erase", d, 8'hA5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_busy_ignore();
    t_prot_prog();
    t_prot_erase();
    t_partial_erase();
    t_both_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule